// File: doc/BRIEF.md
# Power Island On/Off Sequencer

This controller moves a single switchable power island between its off and on states through a fixed series of single-bit steps. It owns a 12-bit control word that drives the island's reset release, isolation clamp, two power-switch enables, clock gate and SRAM power-down field. It watches a pair of power-status inputs and a 4-bit SRAM acknowledge field. Around each sequence it coordinates with an external bus-isolation unit through a request/acknowledge pair.

Each wait on status or acknowledge has its own bounded timeout. When a wait runs out, the sequence stops where it is and signals an error. A request is only acted on while the block is unlocked, and it is unlocked by writing a key word. The host sees busy, a one-cycle done pulse with an error flag, and a qualified domain state: off, on or in between.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset the control word is the off word: reset released bit0=0, isolation bit1=1, primary switch bit2=0, secondary switch bit3=0, clock disable bit4=1, bits 7:5 zero, SRAM power-down bits 11:8 equal to SRAM_PDN_MASK. The bus-isolation request is 1 when that option is enabled, and busy and done are 0.
- R2: Requests are ignored until a key write carries 0x0B16 in bits 31:16 with bit 0 set. Any key write with another value locks the block again.
- R3: Power-on changes the control word one step per clock, in this order: set bit2, set bit3, wait until the island reads on, clear bit4, clear bit1, set bit0, clear the SRAM field bits. Only one of bits 4:0, or else only the SRAM field, changes on any clock.
- R4: Power-off first engages bus isolation. It then sets the SRAM field bits, waits on the acknowledge, then sets bit1, clears bit0, sets bit4, clears bit2 and clears bit3, and finally waits until the island reads off.
- R5: dom_state is 2'b01 when both status inputs are 1 and 2'b00 when both are 0. When exactly one is 1 it is 2'b10, which never counts as on.
- R6: The power-on wait ends only when both status inputs are 1. The power-off wait ends only when both are 0.
- R7: The acknowledge waits look only at the bits in ACK_MASK. Power-on waits for those bits to be 0 and power-off waits for them to be 1; an empty mask passes at once.
- R8: Each wait lasts at most CLK_MHZ*TIMEOUT_US cycles. On expiry the block ends with done and err together, skips all later steps and leaves the control word and bus request as they were.
- R9: When bus isolation is enabled, power-off raises the request and waits for the acknowledge to be 1 before any control change. Power-on drops the request as its last step and waits for the acknowledge to be 0.
- R10: A request that arrives while busy is ignored and does not start a sequence after the running one ends.
- R11: busy is 1 from the clock after acceptance until the clock on which done pulses for one cycle. err is only ever 1 together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_wr_i | input | 1 | Key write strobe |
| key_val_i | input | 32 | Key write value |
| req_on_i | input | 1 | Power-on request |
| req_off_i | input | 1 | Power-off request |
| sta_pri_i | input | 1 | First power-status bit |
| sta_sec_i | input | 1 | Second power-status bit |
| sram_ack_i | input | 4 | SRAM power-down acknowledge field |
| bus_iso_ack_i | input | 1 | Bus-isolation acknowledge |
| ctrl_o | output | 12 | Island control word |
| bus_iso_req_o | output | 1 | Bus-isolation request |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Timeout flag, valid with done |
| dom_state_o | output | 2 | Qualified domain state |

## Verification
The assertions assume that the status, acknowledge and bus-isolation inputs are already synchronous to the block clock. They also assume that those inputs only move in response to the control word and the bus request, never on their own. The bench meets this with a small island model. On each falling edge it makes the switch status follow the switch enables, the masked acknowledge bits follow the SRAM field, and the bus acknowledge follow the request. The unmasked acknowledge bits are held opposite to what a wait would accept. Stalls are made only by freezing one follower, which yields the timeout cases without any glitch on the inputs.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   localparam int BIT_RSTB   = 0;
   localparam int BIT_ISO    = 1;
   localparam int BIT_PRI    = 2;
   localparam int BIT_SEC    = 3;
   localparam int BIT_CLKDIS = 4;
   localparam int SRAM_LSB   = 8;
   localparam int SRAM_W     = 4;
   localparam int CTRL_W     = SRAM_LSB + SRAM_W;

   typedef enum logic [1:0] {
      DOM_OFF   = 2'b00,
      DOM_ON    = 2'b01,
      DOM_TRANS = 2'b10
   } dom_e;

   typedef enum logic [4:0] {
      S_IDLE,
      S_ON_PRI, S_ON_SEC, S_ON_WPWR, S_ON_CLK, S_ON_ISO, S_ON_RST,
      S_ON_SRAM, S_ON_WACK, S_ON_BUS, S_ON_WBUS,
      S_OFF_BUS, S_OFF_WBUS, S_OFF_SRAM, S_OFF_WACK, S_OFF_ISO,
      S_OFF_RST, S_OFF_CLK, S_OFF_PRI, S_OFF_SEC, S_OFF_WPWR
   } seq_state_e;

   function automatic logic is_wait(seq_state_e s);
      return (s == S_ON_WPWR) || (s == S_ON_WACK) || (s == S_ON_WBUS) ||
             (s == S_OFF_WBUS) || (s == S_OFF_WACK) || (s == S_OFF_WPWR);
   endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int LIMIT = 20000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (load_i)        cnt_q <= CW'(LIMIT - 1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_status.sv
module pwr_seq_status
   import pwr_seq_pkg::*;
(
   input  logic pri_i,
   input  logic sec_i,
   output logic on_o,
   output logic off_o,
   output dom_e state_o
);
   always_comb begin
      on_o  = pri_i & sec_i;
      off_o = ~pri_i & ~sec_i;
      if (on_o)       state_o = DOM_ON;
      else if (off_o) state_o = DOM_OFF;
      else            state_o = DOM_TRANS;
   end
endmodule

// File: rtl/pwr_seq_key.sv
module pwr_seq_key #(
   parameter logic [15:0] KEY_TAG = 16'h0B16
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        key_wr_i,
   input  logic [31:0] key_val_i,
   output logic        unlocked_o
);
   logic unused_key_bits;
   assign unused_key_bits = ^key_val_i[15:1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       unlocked_o <= 1'b0;
      else if (key_wr_i) unlocked_o <= (key_val_i[31:16] == KEY_TAG) && key_val_i[0];
   end
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
   import pwr_seq_pkg::*;
#(
   parameter int          CLK_MHZ       = 200,
   parameter int          TIMEOUT_US    = 100,
   parameter logic [3:0]  SRAM_PDN_MASK = 4'hF,
   parameter logic [3:0]  ACK_MASK      = 4'hF,
   parameter bit          BUS_ISO_EN    = 1'b1,
   parameter logic [15:0] KEY_TAG       = 16'h0B16
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        key_wr_i,
   input  logic [31:0] key_val_i,
   input  logic        req_on_i,
   input  logic        req_off_i,
   input  logic        sta_pri_i,
   input  logic        sta_sec_i,
   input  logic [3:0]  sram_ack_i,
   input  logic        bus_iso_ack_i,
   output logic [11:0] ctrl_o,
   output logic        bus_iso_req_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        err_o,
   output logic [1:0]  dom_state_o
);
   localparam int LIMIT = CLK_MHZ * TIMEOUT_US;
   localparam logic [CTRL_W-1:0] CTRL_OFF =
      CTRL_W'((1 << BIT_ISO) | (1 << BIT_CLKDIS)) |
      (CTRL_W'(SRAM_PDN_MASK) << SRAM_LSB);

   if (CLK_MHZ < 1 || TIMEOUT_US < 1) begin : g_bad_time
      $error("pwr_island_seq: CLK_MHZ and TIMEOUT_US must be at least 1");
   end
   if (!($countones(ACK_MASK) inside {0, 1, 2, 4})) begin : g_bad_mask
      $error("pwr_island_seq: ACK_MASK must cover 0, 1, 2 or 4 bits");
   end

   seq_state_e        state_q, state_d;
   logic [CTRL_W-1:0] ctrl_q;
   logic              bus_req_q, done_q, err_q;
   logic              fin_ok, fin_err, expired, unlocked, is_on, is_off;
   dom_e              dom;

   pwr_seq_key #(.KEY_TAG(KEY_TAG)) u_key (
      .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr_i),
      .key_val_i(key_val_i), .unlocked_o(unlocked));

   pwr_seq_status u_sta (
      .pri_i(sta_pri_i), .sec_i(sta_sec_i),
      .on_o(is_on), .off_o(is_off), .state_o(dom));

   pwr_seq_timer #(.LIMIT(LIMIT)) u_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(is_wait(state_d) && (state_d != state_q)),
      .expired_o(expired));

   always_comb begin
      state_d = state_q;
      fin_ok  = 1'b0;
      fin_err = 1'b0;
      unique case (state_q)
         S_IDLE: if (unlocked) begin
            if (req_on_i)       state_d = S_ON_PRI;
            else if (req_off_i) state_d = BUS_ISO_EN ? S_OFF_BUS : S_OFF_SRAM;
         end
         S_ON_PRI:  state_d = S_ON_SEC;
         S_ON_SEC:  state_d = S_ON_WPWR;
         S_ON_WPWR: if (is_on) state_d = S_ON_CLK;
                    else if (expired) fin_err = 1'b1;
         S_ON_CLK:  state_d = S_ON_ISO;
         S_ON_ISO:  state_d = S_ON_RST;
         S_ON_RST:  state_d = S_ON_SRAM;
         S_ON_SRAM: state_d = S_ON_WACK;
         S_ON_WACK: if ((sram_ack_i & ACK_MASK) == '0) begin
                       if (BUS_ISO_EN) state_d = S_ON_BUS;
                       else            fin_ok  = 1'b1;
                    end else if (expired) fin_err = 1'b1;
         S_ON_BUS:  state_d = S_ON_WBUS;
         S_ON_WBUS: if (!bus_iso_ack_i) fin_ok = 1'b1;
                    else if (expired)   fin_err = 1'b1;
         S_OFF_BUS:  state_d = S_OFF_WBUS;
         S_OFF_WBUS: if (bus_iso_ack_i) state_d = S_OFF_SRAM;
                     else if (expired)  fin_err = 1'b1;
         S_OFF_SRAM: state_d = S_OFF_WACK;
         S_OFF_WACK: if ((sram_ack_i & ACK_MASK) == ACK_MASK) state_d = S_OFF_ISO;
                     else if (expired) fin_err = 1'b1;
         S_OFF_ISO:  state_d = S_OFF_RST;
         S_OFF_RST:  state_d = S_OFF_CLK;
         S_OFF_CLK:  state_d = S_OFF_PRI;
         S_OFF_PRI:  state_d = S_OFF_SEC;
         S_OFF_SEC:  state_d = S_OFF_WPWR;
         S_OFF_WPWR: if (is_off) fin_ok = 1'b1;
                     else if (expired) fin_err = 1'b1;
         default:    state_d = S_IDLE;
      endcase
      if (fin_ok || fin_err) state_d = S_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= S_IDLE;
         ctrl_q    <= CTRL_OFF;
         bus_req_q <= 1'b1;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= fin_ok | fin_err;
         err_q   <= fin_err;
         unique case (state_q)
            S_ON_PRI:   ctrl_q[BIT_PRI]    <= 1'b1;
            S_ON_SEC:   ctrl_q[BIT_SEC]    <= 1'b1;
            S_ON_CLK:   ctrl_q[BIT_CLKDIS] <= 1'b0;
            S_ON_ISO:   ctrl_q[BIT_ISO]    <= 1'b0;
            S_ON_RST:   ctrl_q[BIT_RSTB]   <= 1'b1;
            S_ON_SRAM:  ctrl_q[SRAM_LSB +: SRAM_W] <= ctrl_q[SRAM_LSB +: SRAM_W] & ~SRAM_PDN_MASK;
            S_ON_BUS:   bus_req_q <= 1'b0;
            S_OFF_BUS:  bus_req_q <= 1'b1;
            S_OFF_SRAM: ctrl_q[SRAM_LSB +: SRAM_W] <= ctrl_q[SRAM_LSB +: SRAM_W] | SRAM_PDN_MASK;
            S_OFF_ISO:  ctrl_q[BIT_ISO]    <= 1'b1;
            S_OFF_RST:  ctrl_q[BIT_RSTB]   <= 1'b0;
            S_OFF_CLK:  ctrl_q[BIT_CLKDIS] <= 1'b1;
            S_OFF_PRI:  ctrl_q[BIT_PRI]    <= 1'b0;
            S_OFF_SEC:  ctrl_q[BIT_SEC]    <= 1'b0;
            default: ;
         endcase
      end
   end

   if (BUS_ISO_EN) begin : g_bus_iso
      assign bus_iso_req_o = bus_req_q;
   end else begin : g_no_bus_iso
      logic unused_bus;
      assign unused_bus    = bus_req_q ^ bus_iso_ack_i;
      assign bus_iso_req_o = 1'b0;
   end

   assign ctrl_o      = ctrl_q;
   assign busy_o      = (state_q != S_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign dom_state_o = dom;

   AST_LOCKED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == S_IDLE && !unlocked) |=> (state_q == S_IDLE)) else $error("locked start"); // R2
   AST_ONE_CTRL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ctrl_q[4:0] ^ $past(ctrl_q[4:0])) <= 1) else $error("multi step"); // R3
   AST_SRAM_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[11:8] != $past(ctrl_q[11:8])) |-> (ctrl_q[4:0] == $past(ctrl_q[4:0]))) else $error("sram mixed"); // R3
   AST_ON_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == S_ON_CLK) |-> $past(sta_pri_i && sta_sec_i)) else $error("on early"); // R6
   AST_OFF_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(state_q) == S_OFF_WPWR && done_q && !err_q) |-> $past(!sta_pri_i && !sta_sec_i)) else $error("off early"); // R6
   AST_BUS_BEFORE_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (BUS_ISO_EN && state_q == S_OFF_SRAM) |-> $past(bus_iso_ack_i)) else $error("bus ack"); // R9
   AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == S_ON_PRI) |-> ($past(state_q) == S_IDLE)) else $error("restart"); // R10
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o) else $error("done wide"); // R11
   AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> done_o) else $error("err alone"); // R11

endmodule

// File: tb/pwr_island_seq_test.sv
module pwr_island_seq_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int LIMIT = 200 * 2;
   localparam logic [12:0] ON_SEQ [0:6] =
      '{13'h1F16, 13'h1F1E, 13'h1F0E, 13'h1F0C, 13'h1F0D, 13'h100D, 13'h000D};
   localparam logic [12:0] OFF_SEQ [0:6] =
      '{13'h100D, 13'h1F0D, 13'h1F0F, 13'h1F0E, 13'h1F1E, 13'h1F1A, 13'h1F12};

   logic        clk = 1'b0, rst_n = 1'b0, key_wr = 1'b0;
   logic [31:0] key_val = '0;
   logic        req_on = 1'b0, req_off = 1'b0;
   logic        sta_pri = 1'b0, sta_sec = 1'b0, bus_ack = 1'b1;
   logic [3:0]  sram_ack = 4'b0011;
   logic [11:0] ctrl;
   logic        bus_req, busy, done, err;
   logic [1:0]  dom_state;

   int checks = 0, errors = 0;
   bit hold_sec = 0, hold_bus = 0, log_on = 0, finished = 0;
   logic [12:0] trace [$];
   logic [12:0] last_word = 13'h1F12;

   always #2.5 clk = ~clk;

   pwr_island_seq #(.TIMEOUT_US(2), .ACK_MASK(4'b0011)) uut (
      .clk_i(clk), .rst_ni(rst_n), .key_wr_i(key_wr), .key_val_i(key_val),
      .req_on_i(req_on), .req_off_i(req_off), .sta_pri_i(sta_pri),
      .sta_sec_i(sta_sec), .sram_ack_i(sram_ack), .bus_iso_ack_i(bus_ack),
      .ctrl_o(ctrl), .bus_iso_req_o(bus_req), .busy_o(busy), .done_o(done),
      .err_o(err), .dom_state_o(dom_state));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // island model and per-clock comparison of the qualified state
   initial begin
      logic [1:0] exp_dom;
      logic [12:0] word;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            exp_dom = (sta_pri && sta_sec) ? 2'b01 : (!sta_pri && !sta_sec) ? 2'b00 : 2'b10;
            check(dom_state === exp_dom, "R5 dom_state", dom_state, exp_dom);
            word = {bus_req, ctrl};
            if (word !== last_word) begin
               if (log_on) trace.push_back(word);
               last_word = word;
            end
         end
         sta_pri = ctrl[2];
         if (!hold_sec) sta_sec = ctrl[3];
         sram_ack = {~ctrl[11:10], ctrl[9:8]};
         if (!hold_bus) bus_ack = bus_req;
      end
   end

   task automatic write_key(input logic [31:0] v);
      @(negedge clk); key_wr = 1'b1; key_val = v;
      @(negedge clk); key_wr = 1'b0;
   endtask

   task automatic run_seq(input bit on, output int cyc, output bit e);
      @(negedge clk);
      if (on) req_on = 1'b1; else req_off = 1'b1;
      @(negedge clk);
      req_on = 1'b0; req_off = 1'b0;
      check(busy === 1'b1, "R11 busy after accept", busy, 1);
      cyc = 1;
      while (done !== 1'b1 && cyc < LIMIT + 50) begin
         @(negedge clk); cyc++;
      end
      e = err;
      check(done === 1'b1, "R11 done seen", done, 1);
      check(busy === 1'b0, "R11 busy low at done", busy, 0);
      @(negedge clk);
      check(done === 1'b0, "R11 done one cycle", done, 0);
      check(err === 1'b0, "R11 err only with done", err, 0);
   endtask

   task automatic check_trace(input logic [12:0] exp [0:6], input string tag);
      check(trace.size() == 7, {tag, " step count"}, trace.size(), 7);
      for (int i = 0; i < 7 && i < trace.size(); i++)
         check(trace[i] === exp[i], tag, trace[i], exp[i]);
   endtask

   task automatic idle_check(input string tag, input logic [12:0] exp_word);
      repeat (6) @(negedge clk);
      check(busy === 1'b0, {tag, " busy"}, busy, 0);
      check({bus_req, ctrl} === exp_word, {tag, " word"}, {bus_req, ctrl}, exp_word);
   endtask

   initial begin
      int cyc;
      bit e;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ctrl === 12'hF12, "R1 ctrl reset", ctrl, 12'hF12);
      check(bus_req === 1'b1, "R1 bus request reset", bus_req, 1);
      check(busy === 1'b0 && done === 1'b0, "R1 busy/done reset", {busy, done}, 0);
      rst_n = 1'b1;

      // R2 locked after reset, wrong key keeps it locked
      @(negedge clk); req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      idle_check("R2 locked", 13'h1F12);
      write_key(32'h0B16_0000);
      @(negedge clk); req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      idle_check("R2 bit0 clear", 13'h1F12);
      write_key(32'h0B16_0001);

      // R3 R7 R9 power-on order
      trace.delete(); log_on = 1;
      run_seq(1, cyc, e);
      log_on = 0;
      check(e === 1'b0, "R6 R7 power-on no error", e, 0);
      check_trace(ON_SEQ, "R3 R9 power-on order");
      check(dom_state === 2'b01, "R5 on state", dom_state, 1);

      // R4 R9 power-off order
      trace.delete(); log_on = 1;
      run_seq(0, cyc, e);
      log_on = 0;
      check(e === 1'b0, "R4 power-off no error", e, 0);
      check_trace(OFF_SEQ, "R4 R9 power-off order");
      check(dom_state === 2'b00, "R6 off state", dom_state, 0);

      // R10 requests while busy are ignored
      @(negedge clk); req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      repeat (2) @(negedge clk);
      req_off = 1'b1; @(negedge clk); req_off = 1'b0; req_on = 1'b1;
      @(negedge clk); req_on = 1'b0;
      cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
      check(err === 1'b0, "R10 on completes", err, 0);
      idle_check("R10 no late start", 13'h000D);

      // R8 R9 bus acknowledge stalls during power-off
      hold_bus = 1;
      run_seq(0, cyc, e);
      check(e === 1'b1, "R8 bus timeout error", e, 1);
      check(cyc >= LIMIT && cyc <= LIMIT + 5, "R8 bus timeout length", cyc, LIMIT);
      idle_check("R8 R9 steps skipped", 13'h100D);
      hold_bus = 0;
      @(negedge clk);
      run_seq(0, cyc, e);
      check(e === 1'b0 && ctrl === 12'hF12, "R4 recovery off", {e, ctrl}, 12'hF12);

      // R6 R8 secondary status stalls during power-on
      hold_sec = 1;
      run_seq(1, cyc, e);
      check(e === 1'b1, "R6 R8 status timeout error", e, 1);
      check(cyc >= LIMIT && cyc <= LIMIT + 5, "R8 status timeout length", cyc, LIMIT);
      check(dom_state === 2'b10, "R5 transitional", dom_state, 2);
      idle_check("R8 later steps skipped", 13'h1F1E);
      hold_sec = 0;
      @(negedge clk);
      run_seq(0, cyc, e);
      check(e === 1'b0 && ctrl === 12'hF12, "R6 off after stall", {e, ctrl}, 12'hF12);

      // R2 relock with a wrong key
      write_key(32'h0C16_0001);
      @(negedge clk); req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      idle_check("R2 relocked", 13'h1F12);

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule